// File: doc/BRIEF.md
# Q15 Fractional Fixed-Point Multiplier

This block multiplies two signed 16-bit two's-complement operands and delivers a 32-bit product together with a 16-bit narrowed result. A per-transaction mode bit chooses how the operands are interpreted. In integer mode the radix point sits right of the least significant bit and the 32-bit output is the plain signed product. In fractional mode each operand is a Q15 number: a sign bit of weight −1 followed by fifteen bits of halving weight, spanning −1 up to 32767/32768. A Q15 by Q15 product lands in Q30. The block therefore shifts it left by one place to give a proper Q31 word, and takes the top half of that word as the Q15 result. For example, 0x4000 (0.5) times 0x2000 (0.25) yields 0x10000000 and 0x1000 (one eighth).

The pair −1 × −1 is the only fractional product that cannot be represented. It is clamped to the largest positive values, and a sticky flag records that a clamp happened. The Q15 result truncates unless the round bit of the transaction is set. In that case half of a Q15 step is added to the Q31 word before it is narrowed, with clamping if the sum overflows.

Data enters and leaves through valid/ready streams with one register stage between them. An operand set is taken on a rising edge where `in_valid` and `in_ready` are both high. Its result is presented from the following cycle until a rising edge with `out_ready` high. While a result is waiting and `out_ready` is low, `in_ready` is low and the output holds. When the downstream side is ready, a new operand set can be accepted in the same cycle that the old result leaves, so the block sustains one product per clock.

Top module: `qmul_q15`

## Requirements
- R1: With `in_frac`=0, `out_wide` equals the 32-bit signed product of `in_a` and `in_b`, with no shift applied (0x8000 × 0x8000 gives 0x40000000 and no clamp).
- R2: With `in_frac`=1 and not both operands 0x8000, `out_wide` equals the signed product shifted left by one bit (Q31).
- R3: With `in_round`=0, `out_q15` equals bits [31:16] of `out_wide`, in both modes.
- R4: With `in_frac`=1 and `in_round`=1, `out_q15` equals bits [31:16] of (Q31 word + 0x00008000), clamped to 0x7FFF if that addition overflows.
- R5: With `in_frac`=1 and both operands 0x8000, `out_wide` is 0x7FFFFFFF and `out_q15` is 0x7FFF.
- R6: `sat_sticky` rises together with the result of the first clamped transaction and stays high until reset. Integer-mode transactions never set it.
- R7: A set accepted on one rising edge produces `out_valid`=1 with its result after that edge, and `out_valid` is low when no result is pending.
- R8: `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid`=1 and `out_ready`=0, `out_wide` and `out_q15` stay unchanged.
- R9: A synchronous active-high `rst` clears `out_valid`, `out_wide`, `out_q15` and `sat_sticky`.
- R10: With `in_frac`=0, `in_round` has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Block can take an operand set this cycle |
| in_a | input | 16 | First operand, two's complement |
| in_b | input | 16 | Second operand, two's complement |
| in_frac | input | 1 | 1 = Q15 fractional mode, 0 = integer mode |
| in_round | input | 1 | 1 = round the Q15 result, 0 = truncate |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_wide | output | 32 | Integer product or Q31 product |
| out_q15 | output | 16 | Upper half, truncated or rounded |
| sat_sticky | output | 1 | A fractional clamp has occurred since reset |

## Verification
The worked Q15 example separates a correct one-bit realignment from an unshifted or doubly shifted product. The 0x8000 pair is applied in both modes, which tells apart the clamp, the mode gating of the clamp and the integer path that must not clamp. Operand pairs that leave exactly half a Q15 step, with positive and with negative signs, show whether rounding adds before narrowing and whether truncation takes bits or rounds toward zero. A long run of corner-biased random operands under randomly stalled `out_ready` shows whether results are held, lost or duplicated under back-pressure.

// File: rtl/qmul_pkg.sv
package qmul_pkg;
  localparam int unsigned QM_OP_W = 16;

  typedef enum logic {
    QM_MODE_INT  = 1'b0,
    QM_MODE_FRAC = 1'b1
  } qm_mode_e;
endpackage

// File: rtl/qmul_product.sv
// Full-width signed product of two operands.
module qmul_product #(
  parameter int unsigned OP_W = qmul_pkg::QM_OP_W,
  localparam int unsigned PW  = 2 * OP_W
) (
  input  logic [OP_W-1:0] a,
  input  logic [OP_W-1:0] b,
  output logic [PW-1:0]   raw,
  output logic            both_min
);
  localparam logic [OP_W-1:0] MIN_CODE = {1'b1, {(OP_W-1){1'b0}}};

  logic signed [PW-1:0] a_ext;
  logic signed [PW-1:0] b_ext;

  // sign extension keeps the product exact in PW bits
  assign a_ext    = {{OP_W{a[OP_W-1]}}, a};
  assign b_ext    = {{OP_W{b[OP_W-1]}}, b};
  assign raw      = a_ext * b_ext;
  assign both_min = (a == MIN_CODE) && (b == MIN_CODE);
endmodule

// File: rtl/qmul_align.sv
// Integer: pass through. Fractional: Q30 -> Q31 with clamp of the -1 x -1 case.
module qmul_align #(
  parameter int unsigned OP_W = qmul_pkg::QM_OP_W,
  localparam int unsigned PW  = 2 * OP_W
) (
  input  qmul_pkg::qm_mode_e mode,
  input  logic [PW-1:0]      raw,
  input  logic               both_min,
  output logic [PW-1:0]      wide,
  output logic               clamp
);
  localparam logic [PW-1:0] WIDE_MAX = {1'b0, {(PW-1){1'b1}}};

  always_comb begin
    wide  = raw;
    clamp = 1'b0;
    if (mode == qmul_pkg::QM_MODE_FRAC) begin
      if (both_min) begin
        wide  = WIDE_MAX;
        clamp = 1'b1;
      end else begin
        wide  = {raw[PW-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/qmul_narrow.sv
// Takes the upper half of the wide word, optionally rounded, with clamp.
module qmul_narrow #(
  parameter int unsigned OP_W = qmul_pkg::QM_OP_W,
  localparam int unsigned PW  = 2 * OP_W
) (
  input  qmul_pkg::qm_mode_e mode,
  input  logic               rnd,
  input  logic [PW-1:0]      wide,
  input  logic               pre_clamp,
  output logic [OP_W-1:0]    half,
  output logic               clamp
);
  localparam logic [PW:0]     HALF_STEP = {{(PW-OP_W+1){1'b0}}, 1'b1, {(OP_W-1){1'b0}}};
  localparam logic [OP_W-1:0] HALF_MAX  = {1'b0, {(OP_W-1){1'b1}}};

  logic [PW:0] sum;
  logic        sum_ovf;

  always_comb begin
    sum     = {wide[PW-1], wide} + ((mode == qmul_pkg::QM_MODE_FRAC && rnd) ? HALF_STEP : '0);
    sum_ovf = sum[PW] ^ sum[PW-1];
    half    = wide[PW-1:OP_W];
    clamp   = 1'b0;
    if (mode == qmul_pkg::QM_MODE_FRAC) begin
      if (pre_clamp || sum_ovf) begin
        half  = HALF_MAX;
        clamp = 1'b1;
      end else begin
        half  = sum[PW-1:OP_W];
      end
    end
  end
endmodule

// File: rtl/qmul_stage.sv
// One register slice with valid/ready and a sticky clamp flag.
module qmul_stage #(
  parameter int unsigned OP_W = qmul_pkg::QM_OP_W,
  localparam int unsigned PW  = 2 * OP_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            up_valid,
  output logic            up_ready,
  input  logic [PW-1:0]   up_wide,
  input  logic [OP_W-1:0] up_half,
  input  logic            up_clamp,
  output logic            dn_valid,
  input  logic            dn_ready,
  output logic [PW-1:0]   dn_wide,
  output logic [OP_W-1:0] dn_half,
  output logic            sticky
);
  logic take;

  assign up_ready = !dn_valid || dn_ready;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_valid <= 1'b0;
      dn_wide  <= '0;
      dn_half  <= '0;
      sticky   <= 1'b0;
    end else if (take) begin
      dn_valid <= 1'b1;
      dn_wide  <= up_wide;
      dn_half  <= up_half;
      sticky   <= sticky | up_clamp;
    end else if (dn_ready) begin
      dn_valid <= 1'b0;
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_wide) && $stable(dn_half)));

  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_ready) |=> dn_valid);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    sticky |=> sticky);

  assert_reset_R9: assert property (@(posedge clk)
    rst |=> (!dn_valid && !sticky));
endmodule

// File: rtl/qmul_q15.sv
module qmul_q15 #(
  parameter int unsigned OP_W = qmul_pkg::QM_OP_W,
  localparam int unsigned PW  = 2 * OP_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OP_W-1:0] in_a,
  input  logic [OP_W-1:0] in_b,
  input  logic            in_frac,
  input  logic            in_round,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [PW-1:0]   out_wide,
  output logic [OP_W-1:0] out_q15,
  output logic            sat_sticky
);
  localparam logic [OP_W-1:0] MIN_CODE = {1'b1, {(OP_W-1){1'b0}}};
  localparam logic [PW-1:0]   WIDE_MAX = {1'b0, {(PW-1){1'b1}}};

  qmul_pkg::qm_mode_e mode;
  logic [PW-1:0]      raw;
  logic               both_min;
  logic [PW-1:0]      wide;
  logic               clamp_w;
  logic [OP_W-1:0]    half;
  logic               clamp_h;

  assign mode = in_frac ? qmul_pkg::QM_MODE_FRAC : qmul_pkg::QM_MODE_INT;

  qmul_product #(.OP_W(OP_W)) u_product (
    .a(in_a), .b(in_b), .raw(raw), .both_min(both_min)
  );

  qmul_align #(.OP_W(OP_W)) u_align (
    .mode(mode), .raw(raw), .both_min(both_min), .wide(wide), .clamp(clamp_w)
  );

  qmul_narrow #(.OP_W(OP_W)) u_narrow (
    .mode(mode), .rnd(in_round), .wide(wide), .pre_clamp(clamp_w),
    .half(half), .clamp(clamp_h)
  );

  qmul_stage #(.OP_W(OP_W)) u_stage (
    .clk(clk), .rst(rst),
    .up_valid(in_valid), .up_ready(in_ready),
    .up_wide(wide), .up_half(half), .up_clamp(clamp_w | clamp_h),
    .dn_valid(out_valid), .dn_ready(out_ready),
    .dn_wide(out_wide), .dn_half(out_q15), .sticky(sat_sticky)
  );

  assert_clamp_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_frac && in_a == MIN_CODE && in_b == MIN_CODE)
      |=> (sat_sticky && out_wide == WIDE_MAX));

  assert_int_noclamp_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_frac && !sat_sticky) |=> !sat_sticky);
endmodule

// File: tb/test_qmul_q15.sv
`timescale 1ns/1ps
module test_qmul_q15;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, in_frac, in_round;
  logic [15:0] in_a, in_b;
  logic        out_valid, out_ready;
  logic [31:0] out_wide;
  logic [15:0] out_q15;
  logic        sat_sticky;

  always #4 clk = ~clk;

  qmul_q15 i_qmul_q15 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_frac(in_frac), .in_round(in_round),
    .out_valid(out_valid), .out_ready(out_ready), .out_wide(out_wide),
    .out_q15(out_q15), .sat_sticky(sat_sticky)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] qw[$];
  logic [15:0] qh[$];
  string       tw[$];
  string       th[$];
  logic        model_sticky = 1'b0;
  logic        prev_hold = 1'b0;
  logic [31:0] prev_wide;
  logic [15:0] prev_half;

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic push_expected(input logic [15:0] a, b, input logic f, r);
    longint p, w, s;
    logic [31:0] ew;
    logic [15:0] eh;
    logic es;
    string tgw, tgh;
    p  = longint'($signed(a)) * longint'($signed(b));
    es = 1'b0;
    if (!f) begin
      ew = p[31:0]; eh = ew[31:16];
      tgw = "R1"; tgh = r ? "R10" : "R3";
    end else if (a == 16'h8000 && b == 16'h8000) begin
      ew = 32'h7FFF_FFFF; eh = 16'h7FFF; es = 1'b1;
      tgw = "R5"; tgh = "R5";
    end else begin
      w = p * 2; ew = w[31:0]; tgw = "R2";
      if (r) begin
        s = w + 64'sd32768; tgh = "R4";
        if (s > 64'sd2147483647) begin eh = 16'h7FFF; es = 1'b1; end
        else eh = s[31:16];
      end else begin
        eh = w[31:16]; tgh = "R3";
      end
    end
    qw.push_back(ew); qh.push_back(eh); tw.push_back(tgw); th.push_back(tgh);
    model_sticky = model_sticky | es;
  endtask

  task automatic step(input logic v, input logic [15:0] a, b,
                      input logic f, r, input logic rdy);
    @(negedge clk);
    in_valid = v; in_a = a; in_b = b; in_frac = f; in_round = r; out_ready = rdy;
    #1;
    chk(sat_sticky == model_sticky, "R6", "sticky", {31'd0, sat_sticky}, {31'd0, model_sticky});
    if (prev_hold) begin
      chk(out_valid && out_wide == prev_wide && out_q15 == prev_half, "R8", "held result",
          out_wide, prev_wide);
    end
    if (out_valid) begin
      if (qw.size() == 0) begin
        chk(1'b0, "R7", "unexpected out_valid", 32'd1, 32'd0);
      end else begin
        chk(out_wide == qw[0], tw[0], "out_wide", out_wide, qw[0]);
        chk(out_q15 == qh[0], th[0], "out_q15", {16'd0, out_q15}, {16'd0, qh[0]});
        if (rdy) begin
          void'(qw.pop_front()); void'(qh.pop_front());
          void'(tw.pop_front()); void'(th.pop_front());
        end
      end
    end else begin
      chk(qw.size() == 0, "R7", "missing out_valid", 32'd0, 32'd1);
    end
    chk(in_ready == (!out_valid || rdy), "R8", "in_ready", {31'd0, in_ready},
        {31'd0, (!out_valid || rdy)});
    if (v && in_ready) push_expected(a, b, f, r);
    prev_hold = out_valid && !rdy;
    prev_wide = out_wide;
    prev_half = out_q15;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    qw.delete(); qh.delete(); tw.delete(); th.delete();
    model_sticky = 1'b0; prev_hold = 1'b0;
    #1;
    chk(!out_valid, "R9", "out_valid after reset", {31'd0, out_valid}, 32'd0);
    chk(out_wide == 32'd0, "R9", "out_wide after reset", out_wide, 32'd0);
    chk(out_q15 == 16'd0, "R9", "out_q15 after reset", {16'd0, out_q15}, 32'd0);
    chk(!sat_sticky, "R9", "sticky after reset", {31'd0, sat_sticky}, 32'd0);
  endtask

  function automatic logic [15:0] pick();
    case ($urandom_range(0, 5))
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'hFFFF;
      3: return 16'h0001;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_a = '0; in_b = '0;
    in_frac = 1'b0; in_round = 1'b0; out_ready = 1'b0;
    do_reset();

    // R2, R3: worked example 0.5 * 0.25
    step(1, 16'h4000, 16'h2000, 1, 0, 1);
    // R7: the result must be present after exactly one edge
    step(0, 16'h0000, 16'h0000, 0, 0, 1);
    chk(qw.size() == 0, "R7", "queue drained", qw.size(), 32'd0);
    // R1: integer -32768 * -32768, no clamp
    step(1, 16'h8000, 16'h8000, 0, 0, 1);
    // R10: integer mode with round set
    step(1, 16'h0001, 16'h4000, 0, 1, 1);
    // R3 and R4: half step, positive then negative
    step(1, 16'h0001, 16'h4000, 1, 0, 1);
    step(1, 16'h0001, 16'h4000, 1, 1, 1);
    step(1, 16'hFFFF, 16'h4000, 1, 0, 1);
    step(1, 16'hFFFF, 16'h4000, 1, 1, 1);
    // R1: mixed sign integer
    step(1, 16'hFFE1, 16'h0010, 0, 0, 1);
    step(0, 16'h0000, 16'h0000, 0, 0, 1);
    chk(!sat_sticky, "R6", "integer never sets sticky", {31'd0, sat_sticky}, 32'd0);
    // R5, R6: clamp case, then sticky persists
    step(1, 16'h8000, 16'h8000, 1, 0, 1);
    step(1, 16'h8000, 16'h8000, 1, 1, 1);
    step(1, 16'h1234, 16'h0100, 1, 0, 1);
    step(0, 16'h0000, 16'h0000, 0, 0, 1);
    chk(sat_sticky, "R6", "sticky held", {31'd0, sat_sticky}, 32'd1);
    // R8: stall with a result pending
    step(1, 16'h7FFF, 16'h7FFF, 1, 1, 0);
    step(1, 16'h0002, 16'h0003, 0, 0, 0);
    step(1, 16'h0002, 16'h0003, 0, 0, 0);
    step(1, 16'h0002, 16'h0003, 0, 0, 1);
    step(0, 16'h0000, 16'h0000, 0, 0, 1);
    // R9: reset with a pending result and sticky set
    step(1, 16'h8000, 16'h8000, 1, 0, 0);
    do_reset();

    // random traffic under random back-pressure
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 3) != 0, pick(), pick(), 1'($urandom),
           1'($urandom), $urandom_range(0, 2) != 0);
    end
    for (int i = 0; i < 4; i++) step(0, 16'h0000, 16'h0000, 0, 0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule